// File: doc/BRIEF.md
# Iterative Bit Scatter/Gather Unit

The unit moves bits between a source word and a result word under the control of a mask. Each set bit of the mask names one position in a sparse layout, and the set bits taken from lowest to highest define a mapping to a dense layout made of consecutive low bits. In scatter mode, consecutive low source bits are spread out onto the mask positions. In gather mode, the source bits found at the mask positions are packed together into the low end of the result. Result bits that the mapping does not reach are zero.

A request is a single transfer on a valid/ready pair carrying the mode, the source and the mask. The unit holds `in_ready` high while it is idle. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. After that, the unit spends one cycle for each set mask bit. In each of those cycles it finds the lowest remaining set bit by counting trailing zeros, moves one bit, and clears that mask bit with `mask & (mask - 1)`. When the working mask becomes zero, it raises `done_o` for one cycle.

While a request is in progress, `in_ready` stays low, and any `in_valid` during that time is ignored: the request is not taken and its data does not reach the result. The output side cannot apply back-pressure. `done_o` is a plain strobe, and `result_o` keeps its value until the next request is taken. The data width is a parameter and may be 32 or 64.

Top module: `bsg_unit`

## Requirements
- R1: With `in_op` = 0 (scatter), the result bit at the position of the k-th lowest set mask bit equals source bit k, counting k from 0.
- R2: With `in_op` = 1 (gather), result bit k equals the source bit at the position of the k-th lowest set mask bit.
- R3: Every result bit that the mapping does not write is zero. A zero mask therefore gives a zero result in both modes.
- R4: `done_o` rises exactly popcount(mask)+1 cycles after the edge that takes the request. For a zero mask, this is the first cycle after that edge.
- R5: `done_o` is high for one cycle only, and `in_ready` is high again in the cycle after `done_o`.
- R6: `in_ready` is low from the cycle after a request is taken through the cycle in which `done_o` is high. An `in_valid` during that time is not taken and does not change the result.
- R7: After `done_o`, `result_o` keeps its value until the next request is taken.
- R8: After reset, `in_ready` is 1, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request is present |
| in_ready | output | 1 | Unit is idle and will take a request |
| in_op | input | 1 | 0 = scatter, 1 = gather |
| in_src | input | DATA_W | Source word |
| in_mask | input | DATA_W | Mask word |
| result_o | output | DATA_W | Result word, valid from `done_o` until the next request is taken |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
If the position finder is wrong, or the step counter goes out of step with it, a bit lands in the wrong place. Such an error shows up in `result_o` at the `done_o` of the affected request, either as a bit outside the mask in scatter mode or as a bit at or above popcount(mask) in gather mode. If the clearing of the working mask is broken, the latency changes, so `done_o` arrives early or late relative to popcount+1, or never arrives at all. If the idle/busy state is wrong, it shows up within one cycle: either a request is taken while busy, or `in_ready` stays low after `done_o`.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic {
    OP_SCATTER = 1'b0,
    OP_GATHER  = 1'b1
  } bsg_op_e;
endpackage

// File: rtl/bsg_lowbit.sv
// Finds the lowest set bit of a word and returns the word with that bit removed.
module bsg_lowbit #(
  parameter int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask,
  output logic [IW-1:0] pos,
  output logic [W-1:0]  rest,
  output logic          empty
);
  always_comb begin
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) pos = i[IW-1:0];
    end
  end

  assign rest  = mask & (mask - W'(1));
  assign empty = ~|mask;
endmodule

// File: rtl/bsg_seq.sv
// Idle/busy sequencer and dense-side step counter.
module bsg_seq #(
  parameter int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          mask_empty,
  output logic          busy,
  output logic          step,
  output logic          done,
  output logic [IW-1:0] idx
);
  assign step = busy & ~mask_empty;
  assign done = busy & mask_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else begin
      if (done) busy <= 1'b0;
      if (step) idx <= idx + IW'(1);
    end
  end
endmodule

// File: rtl/bsg_unit.sv
module bsg_unit #(
  parameter int DATA_W = 64,
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_mask,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  import bsg_pkg::*;

  logic [DATA_W-1:0] mask_r, src_r, res_r, mask_rest;
  bsg_op_e           op_r;
  logic [IW-1:0]     pos, idx;
  logic              busy, step, done, mask_empty, accept;

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;

  bsg_lowbit #(.W(DATA_W)) u_low (
    .mask  (mask_r),
    .pos   (pos),
    .rest  (mask_rest),
    .empty (mask_empty)
  );

  bsg_seq #(.W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .mask_empty (mask_empty),
    .busy       (busy),
    .step       (step),
    .done       (done),
    .idx        (idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= '0;
      src_r  <= '0;
      res_r  <= '0;
      op_r   <= OP_SCATTER;
    end else if (accept) begin
      mask_r <= in_mask;
      src_r  <= in_src;
      res_r  <= '0;
      op_r   <= bsg_op_e'(in_op);
    end else if (step) begin
      mask_r <= mask_rest;
      if (op_r == OP_SCATTER) res_r[pos] <= src_r[idx];
      else                    res_r[idx] <= src_r[pos];
    end
  end

  assign result_o = res_r;
  assign done_o   = done;
endmodule

// File: rtl/bsg_unit_chk.sv
module bsg_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_op,
  input logic [DATA_W-1:0] in_mask,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o
);
  logic [DATA_W-1:0] cap_mask;
  logic              cap_op;
  int unsigned       steps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_mask <= '0;
      cap_op   <= 1'b0;
      steps    <= 0;
    end else if (in_valid && in_ready) begin
      cap_mask <= in_mask;
      cap_op   <= in_op;
      steps    <= 0;
    end else if (!in_ready && !done_o) begin
      steps <= steps + 1;
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> steps == $countones(cap_mask));
  assert_zero_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mask == '0) |=> done_o);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_ready_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> in_ready);
  assert_busy_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !in_ready);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(result_o));
  assert_scatter_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cap_op) |-> (result_o & ~cap_mask) == '0);
  assert_gather_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_op) |-> (result_o >> $countones(cap_mask)) == '0);
endmodule

bind bsg_unit bsg_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_op    (in_op),
  .in_mask  (in_mask),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/bsg_unit_tb.sv
module bsg_unit_tb;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_op = 1'b0;
  logic [W-1:0] in_src = '0;
  logic [W-1:0] in_mask = '0;
  logic [W-1:0] result_o;
  logic         done_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  bsg_unit #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_mask(in_mask),
    .result_o(result_o), .done_o(done_o)
  );

  function automatic logic [W-1:0] ref_scatter(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[k]; k++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_gather(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[k] = s[i]; k++; end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [W-1:0] s, input logic [W-1:0] m,
                        output logic [W-1:0] res, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = s; in_mask = m;
    @(posedge clk);
    #1 in_valid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done_o && lat < 200);
    res = result_o;
  endtask

  task automatic do_case(input logic op, input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] res, exp;
    int lat;
    run_op(op, s, m, res, lat);
    exp = op ? ref_gather(s, m) : ref_scatter(s, m);
    check(res == exp, op ? "R2 gather" : "R1 scatter", res, exp);
    check(lat == $countones(m) + 1, "R4 latency", W'(lat), W'($countones(m) + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] s, m, res, exp, held;
    int lat;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(in_ready == 1'b1, "R8 ready", W'(in_ready), W'(1));
    check(done_o == 1'b0, "R8 done", W'(done_o), W'(0));
    check(result_o == '0, "R8 result", result_o, '0);
    rst_n = 1'b1;

    // R3: zero mask in both modes, one-cycle finish
    run_op(1'b0, '1, '0, res, lat);
    check(res == '0, "R3 zero mask scatter", res, '0);
    check(lat == 1, "R4 zero mask latency", W'(lat), W'(1));
    run_op(1'b1, '1, '0, res, lat);
    check(res == '0, "R3 zero mask gather", res, '0);

    // R1/R2: full mask is identity
    s = {$urandom, $urandom};
    do_case(1'b0, s, '1);
    do_case(1'b1, s, '1);
    // single-bit masks at ends and middle
    do_case(1'b0, 64'h1, 64'h8000_0000_0000_0000);
    do_case(1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    do_case(1'b0, '1, 64'h0000_0001_0000_0000);
    do_case(1'b1, '1, 64'h0000_0000_0000_0001);
    // R3: bits outside the mask in scatter must be zero
    run_op(1'b0, '1, 64'h00F0_0000_0F00_00F0, res, lat);
    check((res & ~64'h00F0_0000_0F00_00F0) == '0, "R3 outside zero", res, 64'h00F0_0000_0F00_00F0);

    // random mix, dense and sparse masks
    for (int n = 0; n < 300; n++) begin
      s = {$urandom, $urandom};
      m = {$urandom, $urandom};
      if (n % 3 == 1) m = m & {$urandom, $urandom};
      if (n % 3 == 2) m = m | {$urandom, $urandom};
      do_case(n[0], s, m);
    end

    // R6: requests while busy are ignored
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b1; in_src = 64'hDEAD_BEEF_0123_4567; in_mask = 64'hFF00_FF00_FF00_FF00;
    @(posedge clk);
    #1 in_src = '1; in_mask = '1; in_op = 1'b0;   // stays valid while busy
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!done_o) check(in_ready == 1'b0, "R6 busy ready low", W'(in_ready), W'(0));
    end while (!done_o && lat < 200);
    check(in_ready == 1'b0, "R6 ready low at done", W'(in_ready), W'(0));
    in_valid = 1'b0;
    exp = ref_gather(64'hDEAD_BEEF_0123_4567, 64'hFF00_FF00_FF00_FF00);
    check(result_o == exp, "R6 ignored request", result_o, exp);
    check(lat == 33, "R4 latency 32 bits", W'(lat), W'(33));
    held = result_o;

    // R5/R7: single pulse, ready returns, result holds
    @(negedge clk);
    check(done_o == 1'b0, "R5 done pulse", W'(done_o), W'(0));
    check(in_ready == 1'b1, "R5 ready back", W'(in_ready), W'(1));
    in_src = {$urandom, $urandom}; in_mask = {$urandom, $urandom};
    repeat (5) @(negedge clk);
    check(result_o == held, "R7 result held", result_o, held);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule